// File: doc/BRIEF.md
# Indirect Address Pointer Register Unit

This block turns one of three 16-bit data-memory pointers into the address for a load or store. It also produces the pointer's write-back when the access has a side effect. Each pointer has no storage of its own. It is made of two neighbouring 8-bit entries of a 32-entry general register file, which sits outside the block. The unit names the two entries it needs on a read port and takes their bytes back. It then forms the effective address and the new pointer value, together with a write enable, all in the same cycle.

There are four access modes. Plain indirect uses the pointer unchanged. Displacement mode adds a 6-bit unsigned offset and leaves the pointer as it was. Post-increment uses the pointer first and then stores it plus one. Pre-decrement subtracts one first, then uses that value and stores it.

Displacement mode is refused on the first pointer. Such a request, or a request naming a pointer that does not exist, raises an illegal flag and produces no address and no write.

Top module: `ptr_unit`

## Requirements
- R1: Pointer select 0 reads register 27 as the high byte and register 26 as the low byte, and write-back goes to those same two registers.
- R2: Pointer select 1 reads register 29 as the high byte and register 28 as the low byte, and write-back goes to those same two registers.
- R3: Pointer select 2 reads register 31 as the high byte and register 30 as the low byte, and write-back goes to those same two registers.
- R4: Mode 0 (plain): the address equals the pointer and `wb_en` is 0.
- R5: Mode 1 (displacement, select 1 or 2 only): the address equals the pointer plus the zero-extended 6-bit `disp`, modulo 2^16, and `wb_en` is 0.
- R6: Mode 2 (post-increment): the address equals the old pointer. `wb_en` is 1, and both write-back bytes together hold the old pointer plus one, modulo 2^16.
- R7: Mode 3 (pre-decrement): the pointer minus one, modulo 2^16, is both the address and the value written back with `wb_en` equal to 1.
- R8: A request with mode 1 on select 0, or with select 3, drives `illegal` to 1. In that case `ea_valid` and `wb_en` are 0, and `ea`, the write-back indices and the write-back data are all zero.
- R9: With `req_valid` at 0, `illegal`, `ea_valid` and `wb_en` are 0, and `ea`, the write-back indices and the write-back data are all zero, whatever the other inputs are.
- R10: A legal request drives `ea_valid` to 1 and `illegal` to 0 in the same cycle, with no register between the inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Access request strobe |
| ptr_sel | input | 2 | Pointer select: 0, 1 or 2; 3 is illegal |
| mode | input | 2 | 0 plain, 1 displacement, 2 post-increment, 3 pre-decrement |
| disp | input | 6 | Unsigned displacement for mode 1 |
| rd_hi_idx | output | 5 | Register index of the pointer's high byte |
| rd_lo_idx | output | 5 | Register index of the pointer's low byte |
| rd_hi_data | input | 8 | High byte returned by the register file |
| rd_lo_data | input | 8 | Low byte returned by the register file |
| ea | output | 16 | Effective data-memory address |
| ea_valid | output | 1 | Address is valid for this access |
| illegal | output | 1 | Request combination is not allowed |
| wb_en | output | 1 | Write the updated pair back |
| wb_hi_idx | output | 5 | Register index for the high write-back byte |
| wb_lo_idx | output | 5 | Register index for the low write-back byte |
| wb_hi_data | output | 8 | Updated pointer high byte |
| wb_lo_data | output | 8 | Updated pointer low byte |

## Verification
The bench builds the unit with its default parameters: 32 registers, 8-bit bytes, three pointers and a 6-bit displacement. At that size every combination of select, mode, displacement and strobe can be swept in full. The sweep is repeated over six pointer values, including 0x0000, 0xFFFF, 0x00FF and 0x0100, so carries and borrows across the byte boundary are covered, along with both wrap points. The three pointers always hold different values, and the other registers hold a known fill, so reading the wrong pair shows up in the address.

// File: rtl/ptr_pkg.sv
// Package: shared mode encoding and pointer placement helper for the
// indirect address pointer unit. Assumes pointers occupy the top
// 2*NUM_PTRS entries of the register file, lowest pointer first.
package ptr_pkg;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_DISP    = 2'd1,
        AM_POSTINC = 2'd2,
        AM_PREDEC  = 2'd3
    } amode_e;

    // Low-byte register index of pointer k.
    function automatic int ptr_base(input int k, input int nregs, input int nptrs);
        return nregs - 2 * (nptrs - k);
    endfunction

endpackage

// File: rtl/ptr_decode.sv
// Module: ptr_decode
// Checks the pointer select and mode for legality and produces the
// register indices of the selected pair. Assumes ptr_sel values at or
// above NUM_PTRS name no pointer, and that pointers below DISP_FIRST
// may not be used with the displacement mode.
module ptr_decode
    import ptr_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int NUM_PTRS   = 3,
    parameter int SEL_W      = 2,
    parameter int DISP_FIRST = 1,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic             req_valid,
    input  logic [SEL_W-1:0] ptr_sel,
    input  amode_e           mode,
    output logic             legal,
    output logic             illegal,
    output logic [IDX_W-1:0] hi_idx,
    output logic [IDX_W-1:0] lo_idx
);

    logic [NUM_PTRS-1:0] hit;
    logic [NUM_PTRS-1:0] disp_ok;
    logic [IDX_W-1:0]    base_tbl [NUM_PTRS];

    // One comparator and one base index per pointer.
    for (genvar k = 0; k < NUM_PTRS; k++) begin : g_ptr
        assign hit[k]      = (ptr_sel == SEL_W'(k));
        assign disp_ok[k]  = (k >= DISP_FIRST);
        assign base_tbl[k] = IDX_W'(ptr_base(k, NUM_REGS, NUM_PTRS));
    end

    logic sel_ok;
    logic mode_ok;

    // Reduce the per-pointer hits into indices and legality terms.
    always_comb begin
        sel_ok  = 1'b0;
        mode_ok = 1'b1;
        lo_idx  = '0;
        for (int k = 0; k < NUM_PTRS; k++) begin
            if (hit[k]) begin
                sel_ok  = 1'b1;
                lo_idx  = base_tbl[k];
                mode_ok = (mode != AM_DISP) || disp_ok[k];
            end
        end
        hi_idx = sel_ok ? lo_idx + IDX_W'(1) : '0;
    end

    // Final legality of the request.
    always_comb begin
        legal   = req_valid && sel_ok && mode_ok;
        illegal = req_valid && !(sel_ok && mode_ok);
    end

    // Legal and illegal are never raised together (R8).
    always_comb begin
        p_legal_excl_r8: assert (!(legal && illegal))
            else $error("legal and illegal both set");
    end

    // A legal select always names an even low index with the high byte next to it (R1).
    always_comb begin
        if (legal) begin
            p_pair_adjacent_r1: assert (hi_idx == lo_idx + IDX_W'(1) && lo_idx[0] == 1'b0)
                else $error("pair indices not adjacent");
        end
    end

endmodule

// File: rtl/ptr_arith.sv
// Module: ptr_arith
// Forms the effective address and the updated pointer for one access.
// Assumes a 16-bit (ADDR_W) pointer; all arithmetic wraps modulo 2^ADDR_W.
// The displacement is unsigned and zero-extended.
module ptr_arith
    import ptr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic [ADDR_W-1:0] ptr,
    input  amode_e            mode,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              upd
);

    logic [ADDR_W-1:0] ptr_inc;
    logic [ADDR_W-1:0] ptr_dec;
    logic [ADDR_W-1:0] ptr_off;

    // Three candidate sums, computed in parallel.
    always_comb begin
        ptr_inc = ptr + ADDR_W'(1);
        ptr_dec = ptr - ADDR_W'(1);
        ptr_off = ptr + ADDR_W'(disp);
    end

    // Mode selects the address, the write-back value and whether to write.
    always_comb begin
        unique case (mode)
            AM_PLAIN:   begin ea = ptr;     next_ptr = ptr;     upd = 1'b0; end
            AM_DISP:    begin ea = ptr_off; next_ptr = ptr;     upd = 1'b0; end
            AM_POSTINC: begin ea = ptr;     next_ptr = ptr_inc; upd = 1'b1; end
            AM_PREDEC:  begin ea = ptr_dec; next_ptr = ptr_dec; upd = 1'b1; end
            default:    begin ea = ptr;     next_ptr = ptr;     upd = 1'b0; end
        endcase
    end

    // Post-increment writes back one more than the address it used (R6).
    always_comb begin
        if (mode == AM_POSTINC) begin
            p_postinc_step_r6: assert (next_ptr - ea == ADDR_W'(1))
                else $error("post-increment step wrong");
        end
    end

    // Pre-decrement uses the value it writes back, one below the old pointer (R7).
    always_comb begin
        if (mode == AM_PREDEC) begin
            p_predec_same_r7: assert (ea == next_ptr && ptr - ea == ADDR_W'(1))
                else $error("pre-decrement address mismatch");
        end
    end

    // Modes without a side effect leave the pointer untouched (R5).
    always_comb begin
        if (!upd) begin
            p_no_side_effect_r5: assert (next_ptr == ptr)
                else $error("pointer changed without update");
        end
    end

endmodule

// File: rtl/ptr_unit.sv
// Module: ptr_unit (top)
// Indirect address pointer unit: reads the selected register pair, forms
// the effective address and the pointer write-back for one load/store in
// the same cycle. Assumes the register file answers the read port
// combinationally. All outputs are zero when no legal request is present.
module ptr_unit
    import ptr_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int REG_W      = 8,
    parameter int NUM_PTRS   = 3,
    parameter int SEL_W      = 2,
    parameter int DISP_W     = 6,
    parameter int DISP_FIRST = 1,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int ADDR_W    = 2 * REG_W
) (
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [1:0]        mode,
    input  logic [DISP_W-1:0] disp,
    output logic [IDX_W-1:0]  rd_hi_idx,
    output logic [IDX_W-1:0]  rd_lo_idx,
    input  logic [REG_W-1:0]  rd_hi_data,
    input  logic [REG_W-1:0]  rd_lo_data,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic              illegal,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_hi_idx,
    output logic [IDX_W-1:0]  wb_lo_idx,
    output logic [REG_W-1:0]  wb_hi_data,
    output logic [REG_W-1:0]  wb_lo_data
);

    amode_e            mode_e;
    logic              legal;
    logic [ADDR_W-1:0] ptr_val;
    logic [ADDR_W-1:0] ea_raw;
    logic [ADDR_W-1:0] next_raw;
    logic              upd_raw;

    // Interpret the mode bits and assemble the pointer from its pair.
    always_comb begin
        mode_e  = amode_e'(mode);
        ptr_val = {rd_hi_data, rd_lo_data};
    end

    ptr_decode #(
        .NUM_REGS   (NUM_REGS),
        .NUM_PTRS   (NUM_PTRS),
        .SEL_W      (SEL_W),
        .DISP_FIRST (DISP_FIRST)
    ) u_decode (
        .req_valid (req_valid),
        .ptr_sel   (ptr_sel),
        .mode      (mode_e),
        .legal     (legal),
        .illegal   (illegal),
        .hi_idx    (rd_hi_idx),
        .lo_idx    (rd_lo_idx)
    );

    ptr_arith #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_arith (
        .ptr      (ptr_val),
        .mode     (mode_e),
        .disp     (disp),
        .ea       (ea_raw),
        .next_ptr (next_raw),
        .upd      (upd_raw)
    );

    // Gate every result with legality so idle and illegal cycles are all-zero.
    always_comb begin
        ea_valid   = legal;
        ea         = legal ? ea_raw : '0;
        wb_en      = legal && upd_raw;
        wb_hi_idx  = wb_en ? rd_hi_idx : '0;
        wb_lo_idx  = wb_en ? rd_lo_idx : '0;
        wb_hi_data = wb_en ? next_raw[ADDR_W-1:REG_W] : '0;
        wb_lo_data = wb_en ? next_raw[REG_W-1:0] : '0;
    end

    // No request means a silent unit (R9).
    always_comb begin
        if (!req_valid) begin
            p_idle_quiet_r9: assert (!ea_valid && !illegal && !wb_en && ea == '0)
                else $error("outputs active without request");
        end
    end

    // An illegal request produces neither address nor write (R8).
    always_comb begin
        if (illegal) begin
            p_illegal_silent_r8: assert (!ea_valid && !wb_en && ea == '0)
                else $error("illegal request produced output");
        end
    end

    // Write-back happens only in the two self-updating modes (R4).
    always_comb begin
        if (wb_en) begin
            p_wb_mode_r4: assert (mode_e == AM_POSTINC || mode_e == AM_PREDEC)
                else $error("write-back in a non-updating mode");
        end
    end

    // A legal request is always answered with a valid address (R10).
    always_comb begin
        if (req_valid && !illegal) begin
            p_legal_answer_r10: assert (ea_valid)
                else $error("legal request without address");
        end
    end

endmodule

// File: tb/ptr_unit_tb.sv
// Bench for ptr_unit: full sweep of select, mode, displacement and strobe
// over several pointer values; expectations computed arithmetically.
module ptr_unit_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        req_valid;
    logic [1:0]  ptr_sel;
    logic [1:0]  mode;
    logic [5:0]  disp;
    logic [4:0]  rd_hi_idx, rd_lo_idx;
    logic [7:0]  rd_hi_data, rd_lo_data;
    logic [15:0] ea;
    logic        ea_valid, illegal, wb_en;
    logic [4:0]  wb_hi_idx, wb_lo_idx;
    logic [7:0]  wb_hi_data, wb_lo_data;

    logic [7:0] rf [32];

    assign rd_hi_data = rf[rd_hi_idx];
    assign rd_lo_data = rf[rd_lo_idx];

    ptr_unit u_dut (
        .req_valid (req_valid), .ptr_sel (ptr_sel), .mode (mode), .disp (disp),
        .rd_hi_idx (rd_hi_idx), .rd_lo_idx (rd_lo_idx),
        .rd_hi_data (rd_hi_data), .rd_lo_data (rd_lo_data),
        .ea (ea), .ea_valid (ea_valid), .illegal (illegal), .wb_en (wb_en),
        .wb_hi_idx (wb_hi_idx), .wb_lo_idx (wb_lo_idx),
        .wb_hi_data (wb_hi_data), .wb_lo_data (wb_lo_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Compare one packed result vector and log a failure line.
    task automatic check(input string tag, input logic [44:0] act, input logic [44:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (v,ill,wb,ea,hidx,lidx,hd,ld)", tag, act, exp);
        end
    endtask

    initial begin
        logic [15:0] pats [6];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h00FF;
        pats[3] = 16'h0100; pats[4] = 16'h7FC1; pats[5] = 16'hA53C;

        req_valid = 0; ptr_sel = 0; mode = 0; disp = 0;
        for (int i = 0; i < 32; i++) rf[i] = 8'(i * 7 + 3);

        // Idle state before any request (R9).
        @(negedge clk); #1;
        check("R9 idle", {ea_valid, illegal, wb_en, ea, wb_hi_idx, wb_lo_idx, wb_hi_data, wb_lo_data}, '0);

        for (int p = 0; p < 6; p++) begin
            logic [15:0] pv [3];
            pv[0] = pats[p];
            pv[1] = pats[p] ^ 16'h5A5A;
            pv[2] = pats[p] + 16'h1234;
            for (int k = 0; k < 3; k++) begin
                rf[26 + 2*k] = pv[k][7:0];
                rf[27 + 2*k] = pv[k][15:8];
            end
            for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++)
            for (int d = 0; d < 64; d++)
            for (int r = 0; r < 2; r++) begin
                logic        lg, il, we;
                logic [15:0] pt, e, nx;
                logic [4:0]  hi, lo;
                string       tag;
                @(negedge clk);
                req_valid = r[0]; ptr_sel = 2'(s); mode = 2'(m); disp = 6'(d);
                #1;
                il = r[0] && (s == 3 || (m == 1 && s == 0));
                lg = r[0] && !il;
                pt = (s < 3) ? pv[s] : 16'h0;
                nx = pt; e = pt; we = 0;
                case (m)
                    0: begin e = pt; end
                    1: begin e = pt + 16'(d); end
                    2: begin e = pt; nx = pt + 16'd1; we = 1; end
                    default: begin nx = pt - 16'd1; e = nx; we = 1; end
                endcase
                hi = 5'(27 + 2*s); lo = 5'(26 + 2*s);
                if (!lg) begin e = 0; we = 0; end
                if (!we) begin nx = 0; hi = 0; lo = 0; end
                if (!r[0])      tag = "R9 idle";
                else if (il)    tag = "R8 illegal";
                else if (m == 0) tag = "R4 plain";
                else if (m == 1) tag = "R5 disp";
                else if (m == 2) tag = "R6 postinc";
                else             tag = "R7 predec";
                if (lg) tag = {tag, (s == 0) ? " R1 X" : (s == 1) ? " R2 Y" : " R3 Z", " R10"};
                tag = $sformatf("%s sel=%0d mode=%0d disp=%0d ptr=%h", tag, s, m, d, pt);
                check(tag, {ea_valid, illegal, wb_en, ea, wb_hi_idx, wb_lo_idx, wb_hi_data, wb_lo_data},
                      {lg, il, we, e, hi, lo, nx[15:8], nx[7:0]});
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule